// File: doc/BRIEF.md
# Four-Operand Signed Adder with Folded Sign Extension

This block is combinational. It adds four 8-bit two's-complement operands and returns an 11-bit two's-complement sum. It does not copy each operand's sign bit into the three upper columns. Instead, the sign bit of every operand is complemented and a single constant is added to the dot diagram. That constant is the sum, worked out at elaboration, of the four all-ones correction fields. It places dots only in the two top columns. Column 8 receives no constant dot.

The eight low columns go through a row of 4:2 compressors that are chained by their side carries. This leaves exactly two terms. The constant dots and the top cell's side carry pass straight into those two terms and are not added in any cell. A ripple carry-propagate adder then produces the result.

A cell's side carry depends only on its four data inputs, so the chain never ripples through more than one cell. The block has no clock and no reset. It is meant to be used as a leaf inside a datapath.

Top module: `quad_sum_fold`

## Requirements
- R1: `sum_out` equals the sum of the four operands, each sign-extended to 11 bits, taken modulo 2^11, for any input combination.
- R2: With all four operands at -128 (0x80), `sum_out` is -512 (0x600), and its bit 10 is 1.
- R3: With all four operands at +127 (0x7F), `sum_out` is 508 (0x1FC). For any inputs, `sum_out` read as signed lies in [-512, 508].
- R4: Operands of mixed sign cancel exactly. For example, {-128, 127, 1, 0} gives 0 and {-1, -1, -1, -1} gives -4 (0x7FC).
- R5: With all operands zero, `sum_out` is zero. The four folded sign corrections cancel the constant exactly.
- R6: A single nonzero operand in any of the four lanes, with the others zero, gives that operand sign-extended to 11 bits.
- R7: Permuting the four operands among the lanes leaves `sum_out` unchanged.
- R8: The two carry-save terms left after the compressor row sum, modulo 2^11, to the same value as `sum_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op0 | input | 8 | Operand lane 0, two's complement |
| op1 | input | 8 | Operand lane 1, two's complement |
| op2 | input | 8 | Operand lane 2, two's complement |
| op3 | input | 8 | Operand lane 3, two's complement |
| sum_out | output | 11 | Signed sum of the four operands, modulo 2^11 |

## Verification
The extreme patterns test the folded constant at both ends of the range:
- All operands at -128 exercise every complemented sign bit at once.
- All operands at +127 exercise the longest carry runs with no sign correction left.

Mixed-sign cancellations and the all-zero input show whether the constant and the inverted sign bits offset each other exactly. Single-lane and permuted inputs separate a wiring fault in one lane from an arithmetic fault. Random vectors cover the carry patterns between the compressor cells that the directed cases miss.

// File: rtl/fsx_pkg.sv
// Package: shared sizes and the folded sign-correction constant.
// Assumes exactly four operands, so that one row of 4:2 cells reduces them
// to two terms, and a result three bits wider than an operand.
package fsx_pkg;
    localparam int OPW  = 8;
    localparam int NOPS = 4;
    localparam int RESW = OPW + 3;

    // Sum of NOPS all-ones fields that start at the sign column, modulo 2^rw.
    function automatic logic [31:0] fold_const(input int w, input int rw);
        logic [31:0] acc;
        logic [31:0] field;
        acc   = '0;
        field = ((32'd1 << rw) - 32'd1) & ~((32'd1 << (w - 1)) - 32'd1);
        for (int k = 0; k < NOPS; k++) begin
            acc = acc + field;
        end
        return acc & ((32'd1 << rw) - 32'd1);
    endfunction
endpackage

// File: rtl/fsx_dot_prep.sv
// Module: builds the dot diagram. The sign bit of every operand is inverted,
// the lower bits pass through, and the pre-summed correction constant is output.
// Assumes two's-complement operands of width W and a result of width RW.
module fsx_dot_prep #(
    parameter int W  = fsx_pkg::OPW,
    parameter int RW = fsx_pkg::RESW
) (
    input  logic [fsx_pkg::NOPS-1:0][W-1:0] ops,
    output logic [fsx_pkg::NOPS-1:0][W-1:0] rows,
    output logic [RW-1:0]                   kconst
);
    localparam logic [31:0] KFULL = fsx_pkg::fold_const(W, RW);

    // Constant dots, fixed at elaboration.
    assign kconst = KFULL[RW-1:0];

    for (genvar g = 0; g < fsx_pkg::NOPS; g++) begin : g_lane
        // Invert the sign bit and pass the magnitude bits through.
        assign rows[g] = {~ops[g][W-1], ops[g][W-2:0]};
    end
endmodule

// File: rtl/fsx_comp42.sv
// Module: one 4:2 compressor cell built from two full-adder stages.
// Assumes co is taken from the first stage only, so it never depends on ci.
module fsx_comp42 (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    input  logic ci,
    output logic s,
    output logic cy,
    output logic co
);
    logic s1;

    // First stage: compress a, b and c into s1 and the side carry.
    always_comb begin
        s1 = a ^ b ^ c;
        co = (a & b) | (a & c) | (b & c);
    end

    // Second stage: fold d and the incoming side carry into the sum and carry.
    always_comb begin
        s  = s1 ^ d ^ ci;
        cy = (s1 & d) | (s1 & ci) | (d & ci);
    end
endmodule

// File: rtl/fsx_comp42_row.sv
// Module: a row of W chained 4:2 cells that reduces four rows to two terms.
// Assumes the rows are aligned on column 0. The top cell's side carry leaves
// the row at column W.
module fsx_comp42_row #(
    parameter int W = fsx_pkg::OPW
) (
    input  logic [fsx_pkg::NOPS-1:0][W-1:0] rows,
    output logic [W-1:0]                    s_vec,
    output logic [W-1:0]                    cy_vec,
    output logic                            co_top
);
    logic [W:0] side;

    // Column 0 has no neighbour below it.
    assign side[0] = 1'b0;
    assign co_top  = side[W];

    for (genvar i = 0; i < W; i++) begin : g_col
        fsx_comp42 u_cell (
            .a  (rows[0][i]),
            .b  (rows[1][i]),
            .c  (rows[2][i]),
            .d  (rows[3][i]),
            .ci (side[i]),
            .s  (s_vec[i]),
            .cy (cy_vec[i]),
            .co (side[i+1])
        );
    end
endmodule

// File: rtl/fsx_cpa.sv
// Module: RW-bit ripple carry-propagate adder. The carry out is dropped, so
// the sum is modulo 2^RW.
// Assumes operands that are already aligned. Zero upper columns reduce to
// plain wiring after constant folding.
module fsx_cpa #(
    parameter int RW = fsx_pkg::RESW
) (
    input  logic [RW-1:0] x,
    input  logic [RW-1:0] y,
    output logic [RW-1:0] z
);
    logic [RW:0] cc;

    assign cc[0] = 1'b0;

    for (genvar i = 0; i < RW; i++) begin : g_bit
        // One full-adder stage of the ripple chain.
        always_comb begin
            z[i]    = x[i] ^ y[i] ^ cc[i];
            cc[i+1] = (x[i] & y[i]) | (x[i] & cc[i]) | (y[i] & cc[i]);
        end
    end
endmodule

// File: rtl/quad_sum_fold.sv
// Module: top level of the four-operand signed adder with folded sign
// extension. It prepares the dots, applies one 4:2 row, merges the constant
// dots without any cell, and finishes with the CPA.
// Assumes four OPW-bit two's-complement operands. For four operands the
// constant has no dot in column OPW, which keeps that column free for the
// top side carry.
module quad_sum_fold #(
    parameter int OPW = fsx_pkg::OPW
) (
    input  logic [OPW-1:0]   op0,
    input  logic [OPW-1:0]   op1,
    input  logic [OPW-1:0]   op2,
    input  logic [OPW-1:0]   op3,
    output logic [OPW+2:0]   sum_out
);
    localparam int RW  = OPW + 3;
    localparam int UPW = RW - OPW - 1;

    logic [fsx_pkg::NOPS-1:0][OPW-1:0] ops;
    logic [fsx_pkg::NOPS-1:0][OPW-1:0] rows;
    logic [RW-1:0]                     kconst;
    logic [OPW-1:0]                    s_vec;
    logic [OPW-1:0]                    cy_vec;
    logic                              co_top;
    logic [RW-1:0]                     term_a;
    logic [RW-1:0]                     term_b;

    assign ops = {op3, op2, op1, op0};

    fsx_dot_prep #(.W(OPW), .RW(RW)) u_prep (
        .ops    (ops),
        .rows   (rows),
        .kconst (kconst)
    );

    fsx_comp42_row #(.W(OPW)) u_row (
        .rows   (rows),
        .s_vec  (s_vec),
        .cy_vec (cy_vec),
        .co_top (co_top)
    );

    // Term A: constant dots on top, the side carry in column OPW, sums below.
    assign term_a = {kconst[RW-1:OPW+1], co_top, s_vec};
    // Term B: carries moved up by one column.
    assign term_b = {{UPW{1'b0}}, cy_vec, 1'b0};

    fsx_cpa #(.RW(RW)) u_cpa (
        .x (term_a),
        .y (term_b),
        .z (sum_out)
    );
endmodule

// File: rtl/fsx_checker.sv
// Checker: property checks for quad_sum_fold, attached with bind.
// Assumes settled combinational values. Immediate checks are re-evaluated
// whenever an input changes.
module fsx_checker #(
    parameter int OPW = 8
) (
    input logic [OPW-1:0] op0,
    input logic [OPW-1:0] op1,
    input logic [OPW-1:0] op2,
    input logic [OPW-1:0] op3,
    input logic [OPW+2:0] term_a,
    input logic [OPW+2:0] term_b,
    input logic [OPW+2:0] sum_out
);
    localparam int RW = OPW + 3;

    logic signed [RW-1:0] ref_sum;
    logic [RW-1:0]        cs_total;

    // Reference sum built from operands sign-extended by replication.
    always_comb begin
        ref_sum  = RW'($signed(op0)) + RW'($signed(op1)) + RW'($signed(op2)) + RW'($signed(op3));
        cs_total = term_a + term_b;
    end

    // Check the properties that hold for every input combination.
    always_comb begin
        assert_sum_match_R1: assert (sum_out == ref_sum)
            else $error("R1 sum mismatch %h vs %h", sum_out, ref_sum);
        assert_range_R3: assert (($signed(sum_out) >= -512) && ($signed(sum_out) <= 508))
            else $error("R3 result out of range %h", sum_out);
        assert_two_terms_R8: assert (cs_total == sum_out)
            else $error("R8 carry-save terms %h disagree with %h", cs_total, sum_out);
        if (op0[OPW-1] && op1[OPW-1] && op2[OPW-1] && op3[OPW-1]) begin
            assert_neg_sign_R2: assert (sum_out[RW-1])
                else $error("R2 all-negative inputs gave non-negative %h", sum_out);
        end
        if ((op0 | op1 | op2 | op3) == '0) begin
            assert_zero_in_R5: assert (sum_out == '0)
                else $error("R5 zero inputs gave %h", sum_out);
        end
    end
endmodule

bind quad_sum_fold fsx_checker #(.OPW(OPW)) u_chk (
    .op0     (op0),
    .op1     (op1),
    .op2     (op2),
    .op3     (op3),
    .term_a  (term_a),
    .term_b  (term_b),
    .sum_out (sum_out)
);

// File: tb/quad_sum_fold_tb.sv
// Bench: directed scenarios, one task each, for quad_sum_fold.
module quad_sum_fold_tb;
    logic        clk;
    logic        rst_n;
    logic [7:0]  op0, op1, op2, op3;
    logic [10:0] sum_out;
    int          n_checks;
    int          n_fail;
    bit          done;

    quad_sum_fold u_dut (
        .op0     (op0),
        .op1     (op1),
        .op2     (op2),
        .op3     (op3),
        .sum_out (sum_out)
    );

    // 100 MHz clock used for pacing and for the watchdog.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [10:0] model(input logic [7:0] a, b, c, d);
        return {{3{a[7]}}, a} + {{3{b[7]}}, b} + {{3{c[7]}}, c} + {{3{d[7]}}, d};
    endfunction

    // Apply one vector, wait for mid-cycle, then compare the result.
    task automatic apply_check(input logic [7:0] a, b, c, d,
                               input logic [10:0] expv, input string req);
        @(posedge clk);
        op0 = a; op1 = b; op2 = c; op3 = d;
        @(negedge clk);
        n_checks++;
        if (sum_out !== expv) begin
            n_fail++;
            $display("FAIL %s: in=%h %h %h %h got %h expected %h", req, a, b, c, d, sum_out, expv);
        end
    endtask

    task automatic t_zero();
        apply_check(8'h00, 8'h00, 8'h00, 8'h00, 11'h000, "R5");
    endtask

    task automatic t_extremes();
        apply_check(8'h80, 8'h80, 8'h80, 8'h80, 11'h600, "R2");
        apply_check(8'h7F, 8'h7F, 8'h7F, 8'h7F, 11'h1FC, "R3");
    endtask

    task automatic t_mixed();
        apply_check(8'h80, 8'h7F, 8'h01, 8'h00, 11'h000, "R4");
        apply_check(8'hFF, 8'hFF, 8'hFF, 8'hFF, 11'h7FC, "R4");
        apply_check(8'h80, 8'h80, 8'h7F, 8'h7F, 11'h7FE, "R4");
    endtask

    task automatic t_single_lane();
        for (int lane = 0; lane < 4; lane++) begin
            logic [7:0] v [4];
            for (int k = 0; k < 4; k++) v[k] = 8'h00;
            v[lane] = 8'h9C;  // -100 -> 0x79C in 11 bits
            apply_check(v[0], v[1], v[2], v[3], 11'h79C, "R6");
            v[lane] = 8'h55;
            apply_check(v[0], v[1], v[2], v[3], 11'h055, "R6");
        end
    endtask

    task automatic t_permute();
        logic [10:0] first;
        apply_check(8'h83, 8'h21, 8'hF0, 8'h7E, model(8'h83, 8'h21, 8'hF0, 8'h7E), "R7");
        first = sum_out;
        apply_check(8'h7E, 8'hF0, 8'h83, 8'h21, first, "R7");
        apply_check(8'h21, 8'h7E, 8'h21 ^ 8'hA2, 8'hF0, first, "R7");
    endtask

    task automatic t_random();
        // Checks R1, and R8 through the final sum of the two terms.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, b, c, d;
            a = 8'($urandom); b = 8'($urandom); c = 8'($urandom); d = 8'($urandom);
            apply_check(a, b, c, d, model(a, b, c, d), "R1/R8");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Main sequence of scenarios.
    initial begin
        n_checks = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0;
        op0 = '0; op1 = '0; op2 = '0; op3 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_extremes();
        t_mixed();
        t_single_lane();
        t_permute();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule